// File: doc/BRIEF.md
# UART Interrupt Request and Receive-Line Wake Controller

This block merges the four status conditions of a serial transmitter and receiver into one sticky interrupt request. The four conditions are transmit buffer empty, transmitter idle, receive data available and receive overrun. Three enable bits gate them. Transmit-empty and transmit-idle each have an enable of their own. The receive enable covers both the data-available condition and the overrun condition. The request sets on the rising edge of any gated condition and then holds until software pulses a clear input.

The second half of the block is a wake-up detector on the raw receive line. The pin passes through a resynchronizer of configurable depth. When the device is in power-down and wake is enabled, a high-to-low transition on the synchronized line produces a single-cycle wake pulse. Outside power-down, or with wake disabled, the detector emits nothing. It still follows the line level, so entering power-down while the line is already low does not count as an edge.

Top module: `uart_irq_wake_ctl`

## Requirements
- R1: With `en_tx_empty`=1, a 0-to-1 change of `st_tx_empty` makes `irq_req` 1 one clock after the clock edge that samples the change.
- R2: With `en_tx_empty`=0, `st_tx_empty` has no effect on `irq_req`.
- R3: With `en_tx_idle`=1, a 0-to-1 change of `st_tx_idle` makes `irq_req` 1 one clock after the clock edge that samples the change.
- R4: With `en_tx_idle`=0, `st_tx_idle` has no effect on `irq_req`.
- R5: With `en_rx`=1, a 0-to-1 change of either `st_rx_avail` or `st_rx_overrun` makes `irq_req` 1 one clock after the clock edge that samples the change.
- R6: With `en_rx`=0, neither `st_rx_avail` nor `st_rx_overrun` has an effect on `irq_req`.
- R7: Once set, `irq_req` stays 1 until `irq_clr`=1 is sampled. It is then 0 in the next cycle, even if the gated conditions are still high, because only their rising edges set it.
- R8: When a new rising condition and `irq_clr` are sampled at the same edge, `irq_req` is 1 in the next cycle.
- R9: With `pwr_down`=1 and `en_wake`=1, a 1-to-0 change of `rx_pin` gives `wake_pulse`=1 for exactly one cycle. The pulse appears SYNC_STAGES+1 clock edges after the change. With the default SYNC_STAGES=2, that is the third edge.
- R10: With `en_wake`=0, no change of `rx_pin` produces a wake pulse.
- R11: With `pwr_down`=0, no change of `rx_pin` produces a wake pulse.
- R12: A 0-to-1 change of `rx_pin` never produces a wake pulse, and no pulse lasts longer than one cycle.
- R13: While `rst_n`=0, and in the first cycle after reset, `irq_req` and `wake_pulse` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_tx_empty | input | 1 | Enables the transmit-empty source |
| en_tx_idle | input | 1 | Enables the transmit-idle source |
| en_rx | input | 1 | Enables the data-available and overrun sources |
| en_wake | input | 1 | Enables wake from the receive pin |
| st_tx_empty | input | 1 | Transmit buffer empty status |
| st_tx_idle | input | 1 | Transmitter idle status |
| st_rx_avail | input | 1 | Received data available status |
| st_rx_overrun | input | 1 | Receive overrun status |
| irq_clr | input | 1 | Software clear pulse for the request flag |
| pwr_down | input | 1 | Device is in power-down |
| rx_pin | input | 1 | Raw asynchronous receive line |
| irq_req | output | 1 | Sticky interrupt request |
| wake_pulse | output | 1 | One-cycle wake-up pulse |

## Verification
The interrupt request is one register after the inputs. Any flag, enable or clear change is driven on a falling clock edge, and its result is read at the next falling edge. Every combination of the three enables and the four status flags is swept this way. The expected request is the OR of the flags, each masked by its enable.

The wake pulse trails the receive pin by SYNC_STAGES+1 edges, which is three with the default depth. After each pin change, the bench samples six consecutive falling edges and expects a 1 only at the third, and only when power-down and wake are both asserted. This also shows that the pulse lasts exactly one cycle and that a rising pin change produces nothing.

// File: rtl/uart_irqw_pkg.sv
package uart_irqw_pkg;

   localparam int NUM_SRC = 4;

   typedef enum int unsigned {
      SRC_TX_EMPTY = 0,
      SRC_TX_IDLE  = 1,
      SRC_RX_AVAIL = 2,
      SRC_RX_OVR   = 3
   } irq_src_e;

   typedef logic [NUM_SRC-1:0] src_vec_t;

endpackage

// File: rtl/uirq_edge_bank.sv
module uirq_edge_bank #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cond_i,
   output logic [WIDTH-1:0] rise_o
);

   initial assert (WIDTH >= 1) else $error("uirq_edge_bank: WIDTH must be at least 1");

   for (genvar g = 0; g < WIDTH; g++) begin : g_src
      logic cond_q;

      always_ff @(posedge clk) begin
         if (!rst_n) cond_q <= 1'b0;
         else        cond_q <= cond_i[g];
      end

      assign rise_o[g] = cond_i[g] & ~cond_q;

      assert_rise_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
         rise_o[g] |=> !rise_o[g]);
   end

endmodule

// File: rtl/uirq_sticky_flag.sv
module uirq_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && clr_i) |=> flag_o);
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);
   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o && !set_i) |=> !flag_o);

endmodule

// File: rtl/uirq_rx_wake.sv
module uirq_rx_wake #(
   parameter int   SYNC_STAGES = 2,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic rx_i,
   output logic wake_o
);

   initial assert (SYNC_STAGES >= 2) else $error("uirq_rx_wake: SYNC_STAGES must be at least 2");

   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   wake_q;
   logic                   fall;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
      else        sync_q <= {sync_q[LAST-1:0], rx_i};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= IDLE_LEVEL;
      else        prev_q <= sync_q[LAST];
   end

   assign fall = prev_q & ~sync_q[LAST];

   always_ff @(posedge clk) begin
      if (!rst_n) wake_q <= 1'b0;
      else        wake_q <= fall & arm_i;
   end

   assign wake_o = wake_q;

   assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |=> !wake_o);
   assert_armed_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> $past(arm_i));

endmodule

// File: rtl/uart_irq_wake_ctl.sv
module uart_irq_wake_ctl
   import uart_irqw_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_tx_empty,
   input  logic en_tx_idle,
   input  logic en_rx,
   input  logic en_wake,
   input  logic st_tx_empty,
   input  logic st_tx_idle,
   input  logic st_rx_avail,
   input  logic st_rx_overrun,
   input  logic irq_clr,
   input  logic pwr_down,
   input  logic rx_pin,
   output logic irq_req,
   output logic wake_pulse
);

   src_vec_t status_vec;
   src_vec_t enable_vec;
   src_vec_t gated_vec;
   src_vec_t rise_vec;

   always_comb begin
      status_vec               = '0;
      enable_vec               = '0;
      status_vec[SRC_TX_EMPTY] = st_tx_empty;
      status_vec[SRC_TX_IDLE]  = st_tx_idle;
      status_vec[SRC_RX_AVAIL] = st_rx_avail;
      status_vec[SRC_RX_OVR]   = st_rx_overrun;
      enable_vec[SRC_TX_EMPTY] = en_tx_empty;
      enable_vec[SRC_TX_IDLE]  = en_tx_idle;
      enable_vec[SRC_RX_AVAIL] = en_rx;
      enable_vec[SRC_RX_OVR]   = en_rx;
   end

   assign gated_vec = status_vec & enable_vec;

   uirq_edge_bank #(.WIDTH(NUM_SRC)) u_edges (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond_i (gated_vec),
      .rise_o (rise_vec)
   );

   uirq_sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (|rise_vec),
      .clr_i  (irq_clr),
      .flag_o (irq_req)
   );

   uirq_rx_wake #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (pwr_down & en_wake),
      .rx_i   (rx_pin),
      .wake_o (wake_pulse)
   );

   assert_txe_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_tx_empty && st_tx_empty) |=> irq_req);
   assert_txi_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_tx_idle && st_tx_idle) |=> irq_req);
   assert_rx_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_rx && (st_rx_avail || st_rx_overrun)) |=> irq_req);
   assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_req && !en_rx && !(en_tx_empty && st_tx_empty) && !(en_tx_idle && st_tx_idle))
      |=> !irq_req);
   assert_wake_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> $past(en_wake && pwr_down));

endmodule

// File: tb/uart_irq_wake_ctl_tb.sv
module uart_irq_wake_ctl_tb;

   logic clk = 1'b0;
   logic rst_n;
   logic en_tx_empty, en_tx_idle, en_rx, en_wake;
   logic st_tx_empty, st_tx_idle, st_rx_avail, st_rx_overrun;
   logic irq_clr, pwr_down, rx_pin;
   logic irq_req, wake_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   uart_irq_wake_ctl #(.SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .en_tx_empty(en_tx_empty), .en_tx_idle(en_tx_idle), .en_rx(en_rx), .en_wake(en_wake),
      .st_tx_empty(st_tx_empty), .st_tx_idle(st_tx_idle),
      .st_rx_avail(st_rx_avail), .st_rx_overrun(st_rx_overrun),
      .irq_clr(irq_clr), .pwr_down(pwr_down), .rx_pin(rx_pin),
      .irq_req(irq_req), .wake_pulse(wake_pulse)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_flags(input logic [3:0] f);
      st_tx_empty   = f[0];
      st_tx_idle    = f[1];
      st_rx_avail   = f[2];
      st_rx_overrun = f[3];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      en_tx_empty = 0; en_tx_idle = 0; en_rx = 0; en_wake = 0;
      set_flags(4'b0000);
      irq_clr = 0; pwr_down = 0; rx_pin = 1'b1;
      repeat (3) @(negedge clk);
      check("R13 irq in reset", irq_req, 1'b0);
      check("R13 wake in reset", wake_pulse, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R13 irq after reset", irq_req, 1'b0);
      check("R13 wake after reset", wake_pulse, 1'b0);

      // R1 R2 R3 R4 R5 R6: sweep of every enable set and flag pattern
      for (int e = 0; e < 8; e++) begin
         for (int f = 0; f < 16; f++) begin
            logic [3:0] emask;
            logic       exp_irq;
            emask   = {e[2], e[2], e[1], e[0]};
            exp_irq = |(emask & f[3:0]);
            en_tx_empty = e[0]; en_tx_idle = e[1]; en_rx = e[2];
            set_flags(4'b0000);
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            check("R7 clear before sweep step", irq_req, 1'b0);
            set_flags(f[3:0]);
            @(negedge clk);
            check("R1 R2 R3 R4 R5 R6 gated set", irq_req, exp_irq);
            set_flags(4'b0000);
            @(negedge clk);
            check("R7 holds after flags drop", irq_req, exp_irq);
         end
      end

      // R7: clear while enabled flags stay high -> cleared, no re-set
      en_tx_empty = 1; en_tx_idle = 1; en_rx = 1;
      set_flags(4'b0000);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      set_flags(4'b0101);
      @(negedge clk);
      check("R5 rx avail sets", irq_req, 1'b1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      check("R7 clear with level held", irq_req, 1'b0);
      repeat (3) @(negedge clk);
      check("R7 level alone does not re-set", irq_req, 1'b0);

      // R5: overrun rising while avail already high
      set_flags(4'b1101);
      @(negedge clk);
      check("R5 overrun edge sets", irq_req, 1'b1);

      // R8: set and clear together
      set_flags(4'b0000);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      check("R7 cleared", irq_req, 1'b0);
      set_flags(4'b0010);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      check("R8 set beats clear", irq_req, 1'b1);
      set_flags(4'b0000);

      // R9 R10 R11 R12: wake sweep
      for (int m = 0; m < 4; m++) begin
         logic armed;
         pwr_down = m[0];
         en_wake  = m[1];
         armed    = m[0] & m[1];
         rx_pin   = 1'b1;
         repeat (5) @(negedge clk);
         check("R11 R10 quiet while idle", wake_pulse, 1'b0);
         rx_pin = 1'b0;
         for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            check(armed ? "R9 falling edge wake" : (m[0] ? "R10 wake disabled" : "R11 not powered down"),
                  wake_pulse, armed && (i == 3));
         end
         rx_pin = 1'b1;
         for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            check("R12 rising edge no wake", wake_pulse, 1'b0);
         end
      end

      // R11: enter power-down with the line already low: no pulse
      pwr_down = 1'b0; en_wake = 1'b1; rx_pin = 1'b0;
      repeat (5) @(negedge clk);
      pwr_down = 1'b1;
      for (int i = 1; i <= 5; i++) begin
         @(negedge clk);
         check("R11 low line at entry no wake", wake_pulse, 1'b0);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule